// File: doc/BRIEF.md
# Condition Register Logic Unit

This block is the combinational execute step for a 32-bit condition register built from eight 4-bit fields. From a decoded operation code, the raw 32-bit instruction word, a 64-bit general operand and the present condition register, it forms the next condition register value and a 64-bit general result. An opaque context vector passes straight through next to the data.

Fields and bits use big-endian numbering. Field index f (0..7) covers register bits (7-f)*4+3 down to (7-f)*4. Bit index n (0..31) refers to register bit 31-n. Four operations are supported:

- masked move into the register;
- move out of the register, in a whole-register form and a one-field form;
- field-to-field copy;
- single-bit boolean combine, whose function is the 4-bit truth table held in the instruction.

The block has no state. Its process for the operation choice is a single `unique case` over the operation code. The states of the style map to operation codes: NOP (0), MTCR (1), MFCR (2), FCOPY (3), BCOMB (4). There are no transitions, because every input change is a fresh evaluation.

Top module: `cr_logic_unit`

## Requirements
- R1: With op_sel=1 (MTCR), mask FXM=insn[19:12] is applied per field. Each field k (bits 4k+3..4k) whose FXM bit k is set takes operand bits 4k+3..4k. Every other field keeps cr_in. gpr_out is zero.
- R2: With op_sel=2 (MFCR) and insn[20]=0, gpr_out equals cr_in zero-extended to 64 bits, and cr_out equals cr_in.
- R3: With op_sel=2 and insn[20]=1, each field k with FXM bit k set appears at bits 4k+3..4k of gpr_out. All other bits of gpr_out, including bits 63..32, are zero. cr_out equals cr_in.
- R4: With op_sel=3 (FCOPY), destination field BF=insn[25:23] receives all four bits of source field BFA=insn[20:18], using big-endian field numbering. All other fields keep cr_in, and gpr_out is zero.
- R5: With op_sel=4 (BCOMB), let A be the bit at BA=insn[20:16] and B the bit at BB=insn[15:11]. Bit BT=insn[25:21] becomes code[{A,B}], where code=insn[9:6] and code[0] is insn[6]. All other bits keep cr_in, and gpr_out is zero.
- R6: The named codes give these functions: 1000 AND, 0100 A AND NOT B, 1001 XNOR, 0111 NAND, 0001 NOR, 1110 OR, 1101 A OR NOT B, 0110 XOR.
- R7: ctx_out always equals ctx_in.
- R8: For op_sel values 0, 5, 6 and 7, cr_out equals cr_in and gpr_out is zero.
- R9: Overlapping indices: BF=BFA leaves the register unchanged, and BT may equal BA or BB, in which case the result is computed from the input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (0 NOP, 1 MTCR, 2 MFCR, 3 FCOPY, 4 BCOMB) |
| insn | input | 32 | Raw instruction word |
| opnd | input | 64 | General operand |
| cr_in | input | 32 | Current condition register |
| ctx_in | input | CTX_W (16) | Operation context |
| cr_out | output | 32 | Updated condition register |
| gpr_out | output | 64 | General result |
| ctx_out | output | CTX_W (16) | Context, passed through |

## Verification
Every result is combinational, so each output is due in the same cycle as the stimulus that produces it, with no register on any path. The bench changes inputs just after a rising clock edge and samples at the following falling edge. This leaves half a period for the logic to settle, and no sample falls on an edge where inputs move. A vector table covers each operation, and directed cases then cover the eight named codes, all sixteen truth-table codes, overlapping indices, the one-field zeroing and the unsupported codes.

// File: rtl/crl_pkg.sv
package crl_pkg;
    typedef enum logic [2:0] {
        CRL_NOP   = 3'd0,
        CRL_MTCR  = 3'd1,
        CRL_MFCR  = 3'd2,
        CRL_FCOPY = 3'd3,
        CRL_BCOMB = 3'd4
    } crl_op_e;

    localparam int FXM_LSB   = 12;
    localparam int ONEF_BIT  = 20;
    localparam int BF_LSB    = 23;
    localparam int BFA_LSB   = 18;
    localparam int BT_LSB    = 21;
    localparam int BA_LSB    = 16;
    localparam int BB_LSB    = 11;
    localparam int CODE_LSB  = 6;
endpackage

// File: rtl/crl_mask_unit.sv
module crl_mask_unit #(
    parameter int NF = 8,
    parameter int FW = 4,
    parameter int GW = 64,
    localparam int CRW = NF * FW
) (
    input  logic [CRW-1:0] cr_in,
    input  logic [GW-1:0]  opnd,
    input  logic [NF-1:0]  fxm,
    input  logic           one_field,
    output logic [CRW-1:0] cr_mt,
    output logic [GW-1:0]  res_mf
);
    logic [CRW-1:0] picked;

    for (genvar k = 0; k < NF; k++) begin : g_fld
        assign cr_mt[k*FW +: FW]  = fxm[k] ? opnd[k*FW +: FW] : cr_in[k*FW +: FW];
        assign picked[k*FW +: FW] = fxm[k] ? cr_in[k*FW +: FW] : '0;
    end

    always_comb begin
        res_mf = '0;
        res_mf[CRW-1:0] = one_field ? picked : cr_in;
    end
endmodule

// File: rtl/crl_field_copy.sv
module crl_field_copy #(
    parameter int NF = 8,
    parameter int FW = 4,
    localparam int CRW = NF * FW,
    localparam int IW = $clog2(NF)
) (
    input  logic [CRW-1:0] cr_in,
    input  logic [IW-1:0]  dst,
    input  logic [IW-1:0]  src,
    output logic [CRW-1:0] cr_fc
);
    logic [FW-1:0] src_val;

    always_comb begin
        src_val = cr_in[(NF - 1 - int'(src)) * FW +: FW];
    end

    for (genvar f = 0; f < NF; f++) begin : g_dst
        localparam int LSB = (NF - 1 - f) * FW;
        assign cr_fc[LSB +: FW] = (int'(dst) == f) ? src_val : cr_in[LSB +: FW];
    end
endmodule

// File: rtl/crl_bit_combine.sv
module crl_bit_combine #(
    parameter int CRW = 32,
    localparam int IW = $clog2(CRW)
) (
    input  logic [CRW-1:0] cr_in,
    input  logic [IW-1:0]  bt,
    input  logic [IW-1:0]  ba,
    input  logic [IW-1:0]  bb,
    input  logic [3:0]     code,
    output logic [CRW-1:0] cr_bc
);
    logic bit_a;
    logic bit_b;
    logic bit_r;

    always_comb begin
        bit_a = cr_in[CRW - 1 - int'(ba)];
        bit_b = cr_in[CRW - 1 - int'(bb)];
        bit_r = code[{bit_a, bit_b}];
    end

    for (genvar b = 0; b < CRW; b++) begin : g_bit
        assign cr_bc[b] = (int'(bt) == CRW - 1 - b) ? bit_r : cr_in[b];
    end
endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit #(
    parameter int NF    = 8,
    parameter int FW    = 4,
    parameter int GW    = 64,
    parameter int IWID  = 32,
    parameter int CTX_W = 16,
    localparam int CRW  = NF * FW,
    localparam int FIW  = $clog2(NF),
    localparam int BIW  = $clog2(CRW)
) (
    input  logic [2:0]       op_sel,
    input  logic [IWID-1:0]  insn,
    input  logic [GW-1:0]    opnd,
    input  logic [CRW-1:0]   cr_in,
    input  logic [CTX_W-1:0] ctx_in,
    output logic [CRW-1:0]   cr_out,
    output logic [GW-1:0]    gpr_out,
    output logic [CTX_W-1:0] ctx_out
);
    import crl_pkg::*;

    crl_op_e        op;
    logic [CRW-1:0] cr_mt;
    logic [CRW-1:0] cr_fc;
    logic [CRW-1:0] cr_bc;
    logic [GW-1:0]  res_mf;

    assign op = crl_op_e'(op_sel);

    crl_mask_unit #(.NF(NF), .FW(FW), .GW(GW)) u_mask (
        .cr_in     (cr_in),
        .opnd      (opnd),
        .fxm       (insn[FXM_LSB +: NF]),
        .one_field (insn[ONEF_BIT]),
        .cr_mt     (cr_mt),
        .res_mf    (res_mf)
    );

    crl_field_copy #(.NF(NF), .FW(FW)) u_copy (
        .cr_in (cr_in),
        .dst   (insn[BF_LSB +: FIW]),
        .src   (insn[BFA_LSB +: FIW]),
        .cr_fc (cr_fc)
    );

    crl_bit_combine #(.CRW(CRW)) u_comb (
        .cr_in (cr_in),
        .bt    (insn[BT_LSB +: BIW]),
        .ba    (insn[BA_LSB +: BIW]),
        .bb    (insn[BB_LSB +: BIW]),
        .code  (insn[CODE_LSB +: 4]),
        .cr_bc (cr_bc)
    );

    always_comb begin
        cr_out  = cr_in;
        gpr_out = '0;
        unique case (op)
            CRL_MTCR:  cr_out  = cr_mt;
            CRL_MFCR:  gpr_out = res_mf;
            CRL_FCOPY: cr_out  = cr_fc;
            CRL_BCOMB: cr_out  = cr_bc;
            default: begin
                cr_out  = cr_in;
                gpr_out = '0;
            end
        endcase
    end

    assign ctx_out = ctx_in;
endmodule

// File: rtl/crl_checker.sv
module crl_checker #(
    parameter int NF    = 8,
    parameter int FW    = 4,
    parameter int GW    = 64,
    parameter int IWID  = 32,
    parameter int CTX_W = 16,
    localparam int CRW  = NF * FW
) (
    input logic [2:0]       op_sel,
    input logic [IWID-1:0]  insn,
    input logic [GW-1:0]    opnd,
    input logic [CRW-1:0]   cr_in,
    input logic [CTX_W-1:0] ctx_in,
    input logic [CRW-1:0]   cr_out,
    input logic [GW-1:0]    gpr_out,
    input logic [CTX_W-1:0] ctx_out
);
    logic [CRW-1:0] keep_mask;

    always_comb begin
        keep_mask = {CRW{1'b1}};
        keep_mask[CRW - 1 - int'(insn[25:21])] = 1'b0;

        p_ctx_pass_r7: assert (ctx_out == ctx_in);

        if (op_sel == 3'd1) begin
            for (int k = 0; k < NF; k++) begin
                p_mtcr_field_r1: assert (cr_out[k*FW +: FW] ==
                    (insn[12 + k] ? opnd[k*FW +: FW] : cr_in[k*FW +: FW]));
            end
        end

        if (op_sel == 3'd2 && !insn[20]) begin
            p_mfcr_whole_r2: assert (gpr_out == GW'(cr_in) && cr_out == cr_in);
        end

        if (op_sel == 3'd2 && insn[20]) begin
            p_mfcr_zero_r3: assert (gpr_out[GW-1:CRW] == '0 && cr_out == cr_in);
        end

        if (op_sel == 3'd4) begin
            p_bcomb_keep_r5: assert (((cr_out ^ cr_in) & keep_mask) == '0);
        end

        if (op_sel == 3'd3 && insn[25:23] == insn[20:18]) begin
            p_fcopy_self_r9: assert (cr_out == cr_in);
        end

        if (op_sel > 3'd4 || op_sel == 3'd0) begin
            p_nop_pass_r8: assert (cr_out == cr_in && gpr_out == '0);
        end
    end
endmodule

bind cr_logic_unit crl_checker #(
    .NF(NF), .FW(FW), .GW(GW), .IWID(IWID), .CTX_W(CTX_W)
) u_chk (
    .op_sel  (op_sel),
    .insn    (insn),
    .opnd    (opnd),
    .cr_in   (cr_in),
    .ctx_in  (ctx_in),
    .cr_out  (cr_out),
    .gpr_out (gpr_out),
    .ctx_out (ctx_out)
);

// File: tb/tb_cr_logic_unit.sv
`timescale 1ns/1ps
module tb_cr_logic_unit;
    logic        clk = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] insn = '0;
    logic [63:0] opnd = '0;
    logic [31:0] cr_in = '0;
    logic [15:0] ctx_in = '0;
    logic [31:0] cr_out;
    logic [63:0] gpr_out;
    logic [15:0] ctx_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cr_logic_unit dut (
        .op_sel (op_sel), .insn (insn), .opnd (opnd), .cr_in (cr_in),
        .ctx_in (ctx_in), .cr_out (cr_out), .gpr_out (gpr_out), .ctx_out (ctx_out)
    );

    // Vector layout: {op[2:0], insn[31:0], opnd[63:0], cr[31:0]}
    localparam logic [130:0] VEC [10] = '{
        {3'd1, 32'h000F_F000, 64'h0123_4567_89AB_CDEF, 32'hFFFF_FFFF},
        {3'd1, 32'h0005_5000, 64'hFFFF_FFFF_0F0F_F0F0, 32'h1234_5678},
        {3'd2, 32'h000F_F000, 64'h0, 32'hDEAD_BEEF},
        {3'd2, 32'h001A_5000, 64'h0, 32'hDEAD_BEEF},
        {3'd3, 32'h0104_0000, 64'h0, 32'h1234_5678},
        {3'd3, 32'h0380_0000, 64'h0, 32'h8765_4321},
        {3'd4, 32'h03E0_0A00, 64'h0, 32'hC000_0000},
        {3'd4, 32'h0023_1180, 64'h0, 32'h5A5A_A5A5},
        {3'd6, 32'hFFFF_FFFF, 64'h55, 32'h0BAD_F00D},
        {3'd0, 32'h0000_0000, 64'h77, 32'h1357_9BDF}
    };

    function automatic logic [63:0] mk_mask(input logic [7:0] fxm, input logic one);
        return 64'((32'(one) << 20) | (32'(fxm) << 12));
    endfunction
    function automatic logic [31:0] mk_copy(input int bf, input int bfa);
        return (32'(bf) << 23) | (32'(bfa) << 18);
    endfunction
    function automatic logic [31:0] mk_comb(input int bt, input int ba, input int bb, input logic [3:0] c);
        return (32'(bt) << 21) | (32'(ba) << 16) | (32'(bb) << 11) | (32'(c) << 6);
    endfunction

    // Reference written bit by bit from the requirements.
    task automatic model(input logic [2:0] op, input logic [31:0] ins, input logic [63:0] od,
                         input logic [31:0] cr, output logic [31:0] ecr, output logic [63:0] eg);
        int bt, ba, bb, bf, bfa;
        logic a, b;
        ecr = cr;
        eg = '0;
        bt = int'(ins[25:21]); ba = int'(ins[20:16]); bb = int'(ins[15:11]);
        bf = int'(ins[25:23]); bfa = int'(ins[20:18]);
        for (int i = 0; i < 32; i++) begin
            if (op == 3'd1 && ins[12 + i/4]) ecr[i] = od[i];
            if (op == 3'd2) eg[i] = (!ins[20] || ins[12 + i/4]) ? cr[i] : 1'b0;
            if (op == 3'd3 && (7 - i/4) == bf) ecr[i] = cr[(7 - bfa)*4 + i%4];
        end
        if (op == 3'd4) begin
            a = cr[31 - ba];
            b = cr[31 - bb];
            ecr[31 - bt] = ins[6 + 2*int'(a) + int'(b)];
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [31:0] ins, input logic [63:0] od,
                         input logic [31:0] cr, input logic [15:0] cx);
        @(posedge clk);
        #0.5;
        op_sel = op; insn = ins; opnd = od; cr_in = cr; ctx_in = cx;
        @(negedge clk);
    endtask

    function automatic logic named_fn(input int idx, input logic a, input logic b);
        case (idx)
            0: return a & b;
            1: return a & ~b;
            2: return ~(a ^ b);
            3: return ~(a & b);
            4: return ~(a | b);
            5: return a | b;
            6: return a | ~b;
            default: return a ^ b;
        endcase
    endfunction

    localparam logic [3:0] NAMED [8] = '{4'b1000, 4'b0100, 4'b1001, 4'b0111,
                                          4'b0001, 4'b1110, 4'b1101, 4'b0110};

    initial begin
        logic [31:0] ecr;
        logic [63:0] eg;
        @(negedge clk);
        check("R8 idle cr_out", 64'(cr_out), 64'h0);
        check("R8 idle gpr_out", gpr_out, 64'h0);
        check("R7 idle ctx_out", 64'(ctx_out), 64'h0);

        for (int v = 0; v < 10; v++) begin
            logic [130:0] e;
            e = VEC[v];
            apply(e[130:128], e[127:96], e[95:32], e[31:0], 16'(v * 16'h1111));
            model(e[130:128], e[127:96], e[95:32], e[31:0], ecr, eg);
            check("R1/R2/R3/R4/R5/R8 table cr_out", 64'(cr_out), 64'(ecr));
            check("R1/R2/R3/R4/R5/R8 table gpr_out", gpr_out, eg);
            check("R7 ctx pass", 64'(ctx_out), 64'(v * 16'h1111));
        end

        // R1 directed
        apply(3'd1, mk_mask(8'h0F, 1'b0), 64'h0123_4567_89AB_CDEF, 32'hFFFF_FFFF, 16'hA001);
        check("R1 low fields", 64'(cr_out), 64'h0000_0000_FFFF_CDEF);
        check("R1 gpr zero", gpr_out, 64'h0);
        // R2 directed
        apply(3'd2, mk_mask(8'h00, 1'b0), 64'h0, 32'hCAFE_1234, 16'hA002);
        check("R2 whole", gpr_out, 64'h0000_0000_CAFE_1234);
        // R3 directed
        apply(3'd2, mk_mask(8'b1000_0001, 1'b1), 64'h0, 32'h1234_5678, 16'hA003);
        check("R3 one field", gpr_out, 64'h0000_0000_1000_0008);
        check("R3 cr unchanged", 64'(cr_out), 64'h1234_5678);
        // R4 directed: field 0 (bits 31:28) into field 7 (bits 3:0)
        apply(3'd3, mk_copy(7, 0), 64'h0, 32'h1234_5678, 16'hA004);
        check("R4 copy", 64'(cr_out), 64'h1234_5671);
        // R9 self copy
        apply(3'd3, mk_copy(3, 3), 64'h0, 32'h1234_5678, 16'hA005);
        check("R9 self copy", 64'(cr_out), 64'h1234_5678);
        // R5: bit0 (msb)=1, bit1=0, target bit 31 (lsb)
        apply(3'd4, mk_comb(31, 0, 1, 4'b1000), 64'h0, 32'h8000_0000, 16'hA006);
        check("R5 AND", 64'(cr_out), 64'h8000_0000);
        apply(3'd4, mk_comb(31, 0, 1, 4'b1110), 64'h0, 32'h8000_0000, 16'hA007);
        check("R5 OR", 64'(cr_out), 64'h8000_0001);
        // R9 target equals source: bit 0 = NOT(bit0 AND bit0) -> clears msb
        apply(3'd4, mk_comb(0, 0, 0, 4'b0111), 64'h0, 32'h8000_00FF, 16'hA008);
        check("R9 in-place NAND", 64'(cr_out), 64'h0000_00FF);

        // R6 named codes over all input pairs
        for (int f = 0; f < 8; f++) begin
            for (int ab = 0; ab < 4; ab++) begin
                logic a, b;
                a = ab[1]; b = ab[0];
                apply(3'd4, mk_comb(20, 3, 9, NAMED[f]), 64'h0,
                      (32'(a) << 28) | (32'(b) << 22), 16'h0);
                check("R6 named code", 64'(cr_out[11]), 64'(named_fn(f, a, b)));
            end
        end

        // R5 all sixteen truth tables
        for (int c = 0; c < 16; c++) begin
            for (int ab = 0; ab < 4; ab++) begin
                apply(3'd4, mk_comb(31, 30, 5, 4'(c)), 64'h0,
                      (32'(ab[1]) << 1) | (32'(ab[0]) << 26) | 32'h00F0_0000, 16'h0);
                check("R5 truth table", 64'(cr_out),
                      64'((32'(ab[1]) << 1) | (32'(ab[0]) << 26) | 32'h00F0_0000 | 32'(c[ab])));
            end
        end

        // R8 unsupported codes
        for (int o = 5; o < 8; o++) begin
            apply(3'(o), 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h2468_ACE0, 16'hBEEF);
            check("R8 unsupported cr", 64'(cr_out), 64'h2468_ACE0);
            check("R8 unsupported gpr", gpr_out, 64'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule